// File: doc/BRIEF.md
# One-Hot Roulette Rotator

This block picks a position out of a ring of N positions, the way a simple electronic roulette does. A load command writes a single active bit into position 0 and clears every other position. While the play input is held, that bit steps one position per clock edge around the ring at full clock rate. When play is released, the bit stops where it is, and that position is the pick. Because a human press lasts an unpredictable number of clock cycles, the stopping point looks random, although nothing in the block is a real random source.

The ring is made by chaining identical 4-bit shift-register slices. The serial output of each slice feeds the serial input of the next, and the last slice feeds back into the first. Next to the one-hot vector, the block gives a binary index of the active position. A synchronous reset empties the ring. On the first clock edge after reset is released, the block loads position 0 on its own, so the ring never stays empty.

Top module: `roulette_ring`

## Requirements
- R1: On a clock edge where rst is high, the position vector becomes all zero, whatever load and play are.
- R2: On the first clock edge after rst goes low, the block loads position 0 (vector value 1, index 0) even if play is high.
- R3: On an edge where load is high, the vector becomes 1 (only bit 0 set) and the index becomes 0.
- R4: On an edge where play is high and load is low, the active bit moves from position i to position i+1. Position N-1 wraps to position 0. The index goes up by one modulo N.
- R5: On an edge where play and load are both low, the vector and the index keep their values.
- R6: When load and play are both high on the same edge, the load happens and no rotation takes place.
- R7: Outside reset and the single edge that follows it, exactly one bit of the vector is set.
- R8: The index always equals the bit position of the set bit in the vector.
- R9: The active bit passes across slice boundaries. For example it moves from position 3 to position 4, and from position N-1 back to position 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Put the active bit at position 0 |
| play | input | 1 | Rotate while high |
| posVec | output | N | One-hot position vector; bit i is position i |
| posIdx | output | $clog2(N) | Binary index of the active position |

## Verification
The hardest case to reach is the wrap from position N-1 back to position 0, where the bit leaves the last slice and enters the first one through the feedback link. The bench first loads the ring, then holds play for a full lap of N edges. It checks the vector and the index after every edge, so both the wrap and every slice boundary are covered. A second hard case is the forced load after reset with play held high. The bench applies reset in the middle of a rotation and releases it while play is still high, so it can see that the forced load wins over the rotation.

// File: rtl/roulette_pkg.sv
package roulette_pkg;
  localparam int SLICE_W = 4;

  typedef struct packed {
    logic loadPulse;
    logic shiftEn;
  } ctrlStrobes_t;
endpackage

// File: rtl/roulette_slice.sv
module roulette_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         loadEn,
  input  logic         shiftEn,
  input  logic [W-1:0] loadVal,
  input  logic         serIn,
  output logic [W-1:0] q,
  output logic         serOut
);
  always_ff @(posedge clk) begin
    if (rst)          q <= '0;
    else if (loadEn)  q <= loadVal;
    else if (shiftEn) q <= {q[W-2:0], serIn};
  end

  assign serOut = q[W-1];

  assert_slice_load_R3: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> q == $past(loadVal));
  assert_slice_reset_R1: assert property (@(posedge clk)
    rst |=> q == '0);
endmodule

// File: rtl/roulette_control.sv
module roulette_control
  import roulette_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         play,
  output ctrlStrobes_t strobes
);
  logic loadReq;

  always_ff @(posedge clk) begin
    if (rst) loadReq <= 1'b1;
    else     loadReq <= 1'b0;
  end

  always_comb begin
    strobes.loadPulse = load | loadReq;
    strobes.shiftEn   = play & ~strobes.loadPulse;
  end

  assert_reset_load_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> strobes.loadPulse);
  assert_load_wins_R6: assert property (@(posedge clk) disable iff (rst)
    load |-> !strobes.shiftEn);
endmodule

// File: rtl/roulette_datapath.sv
module roulette_datapath
  import roulette_pkg::*;
#(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N),
  localparam int NSLICE = N / SLICE_W
) (
  input  logic             clk,
  input  logic             rst,
  input  ctrlStrobes_t     strobes,
  output logic [N-1:0]     posVec,
  output logic [IDX_W-1:0] posIdx
);
  logic [NSLICE-1:0] serLink;

  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    localparam logic [SLICE_W-1:0] LOADV = (k == 0) ? SLICE_W'(1) : '0;
    logic sIn;
    if (k == 0) begin : g_first
      assign sIn = serLink[NSLICE-1];
    end else begin : g_rest
      assign sIn = serLink[k-1];
    end
    roulette_slice #(.W(SLICE_W)) u_slice (
      .clk     (clk),
      .rst     (rst),
      .loadEn  (strobes.loadPulse),
      .shiftEn (strobes.shiftEn),
      .loadVal (LOADV),
      .serIn   (sIn),
      .q       (posVec[k*SLICE_W +: SLICE_W]),
      .serOut  (serLink[k])
    );
  end

  always_comb begin
    posIdx = '0;
    for (int i = 0; i < N; i++)
      if (posVec[i]) posIdx = posIdx | IDX_W'(i);
  end

  logic settled;
  always_ff @(posedge clk) begin
    if (rst) settled <= 1'b0;
    else     settled <= 1'b1;
  end

  assert_one_hot_R7: assert property (@(posedge clk) disable iff (rst)
    settled |-> $countones(posVec) == 1);
  assert_index_step_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.shiftEn && settled) |=>
      (32'(posIdx) == (($past(32'(posIdx)) == N - 1) ? 0 : $past(32'(posIdx)) + 1)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!strobes.shiftEn && !strobes.loadPulse) |=> $stable(posVec));
  assert_index_match_R8: assert property (@(posedge clk) disable iff (rst)
    settled |-> posVec[posIdx]);
endmodule

// File: rtl/roulette_ring.sv
module roulette_ring
  import roulette_pkg::*;
#(
  parameter int N = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             play,
  output logic [N-1:0]     posVec,
  output logic [IDX_W-1:0] posIdx
);
  ctrlStrobes_t strobes;

  roulette_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .play    (play),
    .strobes (strobes)
  );

  roulette_datapath #(.N(N)) u_dp (
    .clk     (clk),
    .rst     (rst),
    .strobes (strobes),
    .posVec  (posVec),
    .posIdx  (posIdx)
  );
endmodule

// File: tb/roulette_ring_bench.sv
module roulette_ring_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;
  localparam int IDX_W = $clog2(N);
  localparam int NVEC = 12;

  typedef struct packed {
    logic    ld;
    logic    pl;
    int      expIdx;
    int      req;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 1, 4}, '{1'b0, 1'b1, 2, 4}, '{1'b0, 1'b1, 3, 4},
    '{1'b0, 1'b1, 4, 9}, '{1'b0, 1'b0, 4, 5}, '{1'b0, 1'b0, 4, 5},
    '{1'b0, 1'b1, 5, 4}, '{1'b1, 1'b1, 0, 6}, '{1'b1, 1'b0, 0, 3},
    '{1'b0, 1'b1, 1, 4}, '{1'b0, 1'b0, 1, 5}, '{1'b1, 1'b0, 0, 3}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic play = 1'b0;
  logic [N-1:0] posVec;
  logic [IDX_W-1:0] posIdx;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  roulette_ring #(.N(N)) u_roulette_ring (
    .clk(clk), .rst(rst), .load(load), .play(play),
    .posVec(posVec), .posIdx(posIdx)
  );

  function automatic string tagName(int r);
    case (r)
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      9: return "R9";
      default: return "R?";
    endcase
  endfunction

  // Checks the vector, the index (R8) and the bit count (R7) against position idx.
  task automatic checkPos(string tag, int idx);
    logic [N-1:0] expVec;
    expVec = N'(1) << idx;
    checks++;
    if (posVec !== expVec || 32'(posIdx) != idx || $countones(posVec) != 1) begin
      errors++;
      $display("FAIL %s/R7/R8: vec=%h idx=%0d expected vec=%h idx=%0d",
               tag, posVec, posIdx, expVec, idx);
    end
  endtask

  task automatic step(logic ld, logic pl);
    load = ld; play = pl;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    // R1: the vector is empty while reset is held
    checks++;
    if (posVec !== '0) begin
      errors++;
      $display("FAIL R1: vec=%h expected 0", posVec);
    end
    rst = 1'b0;
    step(1'b0, 1'b0);
    checkPos("R2", 0);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].ld, VECS[i].pl);
      checkPos(tagName(VECS[i].req), VECS[i].expIdx);
    end

    // R4 and R9: one full lap, which crosses every slice boundary and the wrap
    step(1'b1, 1'b0);
    checkPos("R3", 0);
    for (int k = 1; k <= N + 2; k++) begin
      step(1'b0, 1'b1);
      checkPos(k % N == 0 ? "R9" : "R4", k % N);
    end

    // R1 in the middle of a rotation, then R2 with play still held
    rst = 1'b1;
    step(1'b0, 1'b1);
    checks++;
    if (posVec !== '0) begin
      errors++;
      $display("FAIL R1: vec=%h expected 0", posVec);
    end
    rst = 1'b0;
    step(1'b0, 1'b1);
    checkPos("R2", 0);
    step(1'b0, 1'b1);
    checkPos("R4", 1);
    step(1'b0, 1'b0);
    checkPos("R5", 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule